// File: doc/BRIEF.md
# Stack-Window and Bus-Fault Exception Unit

This unit produces the exception causes of a 32-bit processor core for two kinds of fault. The first is a stack-window fault. Every access made relative to the stack pointer presents its address, and the unit compares that address with a programmable lower bound and a programmable upper bound. Addresses equal to either bound are legal. The second kind is a bus fault. The instruction-fetch side or the data side reports an error response, together with the access type and the virtual address of the failed access.

On a fault, the unit records the faulting address and a cause code. It then raises a single-cycle exception request for the core's trap logic. A bus fault is discarded without trace when the global exception enable is low. It is also discarded when the trap option for its side is off. Stack-window faults do not depend on the global enable.

All inputs are plain per-cycle strobes with no back-pressure. The unit has no ready signal, cannot stall, and accepts one stack check, one bus-fault report and one bound write in every cycle. The exception request is likewise a pulse with no acknowledge. Vectoring, pipeline flush and register saving belong to the consumer.

Top module: `sbx_exc_unit`

## Requirements
- R1: After reset, exc_req is 0, exc_addr is 0 and exc_cause is 5'h00. The lower bound resets to 0 and the upper bound resets to all ones, so no stack address faults.
- R2: A stack check (stk_valid high) faults when stk_addr is below the lower bound or above the upper bound. An address equal to either bound does not fault.
- R3: A stack-window fault sets exc_cause to 5'h07 and exc_addr to the checked address, whatever the value of exc_en.
- R4: When exc_en is low, a bus-fault report (berr_valid high) causes no exception and leaves exc_addr and exc_cause unchanged.
- R5: A bus fault of kind fetch (berr_kind 2'b00) traps only when ifetch_trap_en is high, and it does so with cause 5'h01.
- R6: A bus fault of any other kind (2'b01 load, 2'b10 store, 2'b11 also treated as data side) traps only when data_trap_en is high, and it does so with cause 5'h02.
- R7: A bus-fault trap loads exc_addr with berr_vaddr.
- R8: When a stack-window fault and a trapping bus fault occur in the same cycle, the stack fault wins for both exc_cause and exc_addr.
- R9: A bound write with bnd_we high loads bnd_data into the lower bound when bnd_sel is 0 and into the upper bound when bnd_sel is 1. The new bound applies to checks from the next cycle onward; a check in the write cycle uses the old bound.
- R10: exc_req is high for exactly the one cycle after each faulting cycle. In every other cycle exc_addr and exc_cause keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bnd_we | input | 1 | Bound write strobe |
| bnd_sel | input | 1 | Bound select: 0 lower, 1 upper |
| bnd_data | input | 32 | Bound write value |
| stk_valid | input | 1 | Stack-relative access to be checked |
| stk_addr | input | 32 | Stack-relative access address |
| berr_valid | input | 1 | Bus error response strobe |
| berr_kind | input | 2 | Failed access type: 00 fetch, 01 load, 10 store |
| berr_vaddr | input | 32 | Virtual address of the failed access |
| exc_en | input | 1 | Global exception enable |
| ifetch_trap_en | input | 1 | Instruction-side bus trap option |
| data_trap_en | input | 1 | Data-side bus trap option |
| exc_req | output | 1 | One-cycle hardware exception request |
| exc_addr | output | 32 | Exception address register |
| exc_cause | output | 5 | Exception status cause code |

## Verification
The assertions check a set of cycle-local properties on every cycle:
- the window comparison and the capture of the stack cause;
- the suppression of bus faults by the global enable and by each side's option;
- the cause and address loaded for each trapping bus side;
- the priority of the stack fault;
- the holding of the registers between exceptions.

Some behaviours only the bench scenarios can show. These are the reset bounds, the one-cycle latency of a bound write relative to a check in the same cycle, and exact boundary addresses at programmed bounds. The bench also shows long mixed streams of faults: a reference model follows a bound history and a held register value across many cycles.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_OTHER = 2'b11
  } acc_kind_e;

  localparam int CAUSE_W = 5;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE  = 5'h00,
    CAUSE_IBUS  = 5'h01,
    CAUSE_DBUS  = 5'h02,
    CAUSE_STACK = 5'h07
  } cause_e;

endpackage

// File: rtl/sbx_bound_regs.sv
module sbx_bound_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] lo_bound,
  output logic [AW-1:0] hi_bound
);

  localparam logic [AW-1:0] LO_RST = '0;
  localparam logic [AW-1:0] HI_RST = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_bound <= LO_RST;
      hi_bound <= HI_RST;
    end else if (wr_en) begin
      if (wr_sel) hi_bound <= wr_data;
      else        lo_bound <= wr_data;
    end
  end

endmodule

// File: rtl/sbx_window_chk.sv
module sbx_window_chk #(
  parameter int AW = 32
) (
  input  logic          chk_valid,
  input  logic [AW-1:0] chk_addr,
  input  logic [AW-1:0] lo_bound,
  input  logic [AW-1:0] hi_bound,
  output logic          fault
);

  logic below_lo;
  logic above_hi;

  always_comb begin
    below_lo = chk_addr < lo_bound;
    above_hi = chk_addr > hi_bound;
    fault    = chk_valid && (below_lo || above_hi);
  end

endmodule

// File: rtl/sbx_berr_filter.sv
module sbx_berr_filter
  import sbx_pkg::*;
(
  input  logic                berr_valid,
  input  logic [1:0]          berr_kind,
  input  logic                exc_en,
  input  logic                ifetch_trap_en,
  input  logic                data_trap_en,
  output logic                trap,
  output logic [CAUSE_W-1:0]  cause
);

  logic is_fetch;
  logic side_en;

  always_comb begin
    is_fetch = (acc_kind_e'(berr_kind) == ACC_FETCH);
    side_en  = is_fetch ? ifetch_trap_en : data_trap_en;
    trap     = berr_valid && exc_en && side_en;
    cause    = is_fetch ? CAUSE_IBUS : CAUSE_DBUS;
  end

endmodule

// File: rtl/sbx_exc_capture.sv
module sbx_exc_capture
  import sbx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stk_fault,
  input  logic [AW-1:0]      stk_addr,
  input  logic               bus_trap,
  input  logic [CAUSE_W-1:0] bus_cause,
  input  logic [AW-1:0]      bus_addr,
  output logic               exc_req,
  output logic [AW-1:0]      exc_addr,
  output logic [CAUSE_W-1:0] exc_cause
);

  logic               take;
  logic [AW-1:0]      nxt_addr;
  logic [CAUSE_W-1:0] nxt_cause;

  // stack fault outranks a bus fault in the same cycle
  always_comb begin
    take      = stk_fault || bus_trap;
    nxt_addr  = stk_fault ? stk_addr : bus_addr;
    nxt_cause = stk_fault ? CAUSE_STACK : bus_cause;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_req   <= 1'b0;
      exc_addr  <= '0;
      exc_cause <= CAUSE_NONE;
    end else begin
      exc_req <= take;
      if (take) begin
        exc_addr  <= nxt_addr;
        exc_cause <= nxt_cause;
      end
    end
  end

endmodule

// File: rtl/sbx_exc_unit.sv
module sbx_exc_unit
  import sbx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bnd_we,
  input  logic               bnd_sel,
  input  logic [AW-1:0]      bnd_data,
  input  logic               stk_valid,
  input  logic [AW-1:0]      stk_addr,
  input  logic               berr_valid,
  input  logic [1:0]         berr_kind,
  input  logic [AW-1:0]      berr_vaddr,
  input  logic               exc_en,
  input  logic               ifetch_trap_en,
  input  logic               data_trap_en,
  output logic               exc_req,
  output logic [AW-1:0]      exc_addr,
  output logic [CAUSE_W-1:0] exc_cause
);

  logic [AW-1:0]      lo_bound;
  logic [AW-1:0]      hi_bound;
  logic               stk_fault;
  logic               bus_trap;
  logic [CAUSE_W-1:0] bus_cause;

  sbx_bound_regs #(.AW(AW)) u_bounds (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bnd_we),
    .wr_sel   (bnd_sel),
    .wr_data  (bnd_data),
    .lo_bound (lo_bound),
    .hi_bound (hi_bound)
  );

  sbx_window_chk #(.AW(AW)) u_window (
    .chk_valid (stk_valid),
    .chk_addr  (stk_addr),
    .lo_bound  (lo_bound),
    .hi_bound  (hi_bound),
    .fault     (stk_fault)
  );

  sbx_berr_filter u_berr (
    .berr_valid     (berr_valid),
    .berr_kind      (berr_kind),
    .exc_en         (exc_en),
    .ifetch_trap_en (ifetch_trap_en),
    .data_trap_en   (data_trap_en),
    .trap           (bus_trap),
    .cause          (bus_cause)
  );

  sbx_exc_capture #(.AW(AW)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .stk_fault (stk_fault),
    .stk_addr  (stk_addr),
    .bus_trap  (bus_trap),
    .bus_cause (bus_cause),
    .bus_addr  (berr_vaddr),
    .exc_req   (exc_req),
    .exc_addr  (exc_addr),
    .exc_cause (exc_cause)
  );

endmodule

// File: rtl/sbx_exc_unit_chk.sv
module sbx_exc_unit_chk
  import sbx_pkg::*;
#(
  parameter int AW = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      lo_bound,
  input logic [AW-1:0]      hi_bound,
  input logic               stk_valid,
  input logic [AW-1:0]      stk_addr,
  input logic               berr_valid,
  input logic [1:0]         berr_kind,
  input logic [AW-1:0]      berr_vaddr,
  input logic               exc_en,
  input logic               ifetch_trap_en,
  input logic               data_trap_en,
  input logic               exc_req,
  input logic [AW-1:0]      exc_addr,
  input logic [CAUSE_W-1:0] exc_cause
);

  logic out_of_window;
  assign out_of_window = stk_valid && ((stk_addr < lo_bound) || (stk_addr > hi_bound));

  // R3
  stack_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_window |=> exc_req && exc_cause == CAUSE_STACK && exc_addr == $past(stk_addr));

  // R2
  inside_window_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_of_window && !berr_valid |=> !exc_req);

  // R4
  global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_of_window && !exc_en |=> !exc_req && $stable(exc_addr) && $stable(exc_cause));

  // R5
  fetch_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_of_window && berr_valid && exc_en && berr_kind == 2'b00 && ifetch_trap_en
    |=> exc_req && exc_cause == CAUSE_IBUS);

  // R5
  fetch_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_of_window && berr_kind == 2'b00 && !ifetch_trap_en |=> !exc_req);

  // R6
  data_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_of_window && berr_valid && exc_en && berr_kind != 2'b00 && data_trap_en
    |=> exc_req && exc_cause == CAUSE_DBUS);

  // R7
  bus_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_of_window && berr_valid && exc_en && (berr_kind == 2'b00 ? ifetch_trap_en : data_trap_en)
    |=> exc_addr == $past(berr_vaddr));

  // R8
  stack_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_window && berr_valid |=> exc_cause == CAUSE_STACK);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |-> $stable(exc_addr) && $stable(exc_cause));

  // R10
  cause_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> exc_cause inside {CAUSE_IBUS, CAUSE_DBUS, CAUSE_STACK});

endmodule

bind sbx_exc_unit sbx_exc_unit_chk #(.AW(AW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .lo_bound       (lo_bound),
  .hi_bound       (hi_bound),
  .stk_valid      (stk_valid),
  .stk_addr       (stk_addr),
  .berr_valid     (berr_valid),
  .berr_kind      (berr_kind),
  .berr_vaddr     (berr_vaddr),
  .exc_en         (exc_en),
  .ifetch_trap_en (ifetch_trap_en),
  .data_trap_en   (data_trap_en),
  .exc_req        (exc_req),
  .exc_addr       (exc_addr),
  .exc_cause      (exc_cause)
);

// File: tb/tb_sbx_exc_unit.sv
`timescale 1ns/1ps
module tb_sbx_exc_unit;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bnd_we, bnd_sel;
  logic [AW-1:0] bnd_data;
  logic          stk_valid;
  logic [AW-1:0] stk_addr;
  logic          berr_valid;
  logic [1:0]    berr_kind;
  logic [AW-1:0] berr_vaddr;
  logic          exc_en, ifetch_trap_en, data_trap_en;
  logic          exc_req;
  logic [AW-1:0] exc_addr;
  logic [4:0]    exc_cause;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference model state
  logic [AW-1:0] m_lo, m_hi, m_addr;
  logic [4:0]    m_cause;

  always #2 clk = ~clk;

  sbx_exc_unit #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .bnd_we(bnd_we), .bnd_sel(bnd_sel), .bnd_data(bnd_data),
    .stk_valid(stk_valid), .stk_addr(stk_addr),
    .berr_valid(berr_valid), .berr_kind(berr_kind), .berr_vaddr(berr_vaddr),
    .exc_en(exc_en), .ifetch_trap_en(ifetch_trap_en), .data_trap_en(data_trap_en),
    .exc_req(exc_req), .exc_addr(exc_addr), .exc_cause(exc_cause)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit win_fault(input bit v, input logic [AW-1:0] a,
                                   input logic [AW-1:0] lo, input logic [AW-1:0] hi);
    return v && (a < lo || a > hi);
  endfunction

  function automatic bit bus_fault(input bit v, input logic [1:0] k, input bit ee,
                                   input bit ie, input bit de);
    return v && ee && ((k == 2'b00) ? ie : de);
  endfunction

  // One cycle: drive at negedge, model, sample 1 ns after posedge
  task automatic step(input bit we, input bit sel, input logic [AW-1:0] wd,
                      input bit sv, input logic [AW-1:0] sa,
                      input bit bv, input logic [1:0] bk, input logic [AW-1:0] ba,
                      input bit ee, input bit ie, input bit de, input string tag);
    bit sf, bf, e_req;
    @(negedge clk);
    bnd_we = we; bnd_sel = sel; bnd_data = wd;
    stk_valid = sv; stk_addr = sa;
    berr_valid = bv; berr_kind = bk; berr_vaddr = ba;
    exc_en = ee; ifetch_trap_en = ie; data_trap_en = de;
    sf = win_fault(sv, sa, m_lo, m_hi);
    bf = bus_fault(bv, bk, ee, ie, de);
    e_req = sf || bf;
    if (sf) begin m_addr = sa; m_cause = 5'h07; end
    else if (bf) begin m_addr = ba; m_cause = (bk == 2'b00) ? 5'h01 : 5'h02; end
    if (we) begin
      if (sel) m_hi = wd; else m_lo = wd;
    end
    @(posedge clk);
    #1;
    check({tag, " req"},   64'(exc_req),   64'(e_req));
    check({tag, " addr"},  64'(exc_addr),  64'(m_addr));
    check({tag, " cause"}, 64'(exc_cause), 64'(m_cause));
  endtask

  task automatic idle(input string tag);
    step(0, 0, '0, 0, '0, 0, 2'b00, '0, 1, 1, 1, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0;
    bnd_we = 0; bnd_sel = 0; bnd_data = '0;
    stk_valid = 0; stk_addr = '0;
    berr_valid = 0; berr_kind = 2'b00; berr_vaddr = '0;
    exc_en = 0; ifetch_trap_en = 0; data_trap_en = 0;
    m_lo = '0; m_hi = '1; m_addr = '0; m_cause = 5'h00;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 reset req",   64'(exc_req),   64'd0);
    check("R1 reset addr",  64'(exc_addr),  64'd0);
    check("R1 reset cause", 64'(exc_cause), 64'd0);
    @(negedge clk); rst_n = 1;

    // R1 reset bounds: extremes are legal
    step(0, 0, '0, 1, 32'h0000_0000, 0, 2'b00, '0, 1, 1, 1, "R1 lo extreme");
    step(0, 0, '0, 1, 32'hFFFF_FFFF, 0, 2'b00, '0, 1, 1, 1, "R1 hi extreme");

    // R9 write lower bound, check in same cycle uses old bound
    step(1, 0, 32'h0000_0100, 1, 32'h0000_0050, 0, 2'b00, '0, 1, 1, 1, "R9 same-cycle lo");
    step(1, 1, 32'h0000_01FF, 1, 32'h0000_0300, 0, 2'b00, '0, 1, 1, 1, "R9 same-cycle hi");
    step(0, 0, '0, 1, 32'h0000_0050, 0, 2'b00, '0, 1, 1, 1, "R9 new lo applies");
    idle("R10 hold after trap");

    // R2 boundaries
    step(0, 0, '0, 1, 32'h0000_0100, 0, 2'b00, '0, 1, 1, 1, "R2 equal lo");
    step(0, 0, '0, 1, 32'h0000_01FF, 0, 2'b00, '0, 1, 1, 1, "R2 equal hi");
    step(0, 0, '0, 1, 32'h0000_00FF, 0, 2'b00, '0, 1, 1, 1, "R2 below lo");
    step(0, 0, '0, 1, 32'h0000_0200, 0, 2'b00, '0, 1, 1, 1, "R2 above hi");
    // R3 stack fault ignores exc_en
    step(0, 0, '0, 1, 32'h0000_0010, 0, 2'b00, '0, 0, 0, 0, "R3 no global enable");

    // R4 global disable drops bus faults
    step(0, 0, '0, 0, '0, 1, 2'b00, 32'hAAAA_0000, 0, 1, 1, "R4 fetch dropped");
    step(0, 0, '0, 0, '0, 1, 2'b01, 32'hAAAA_0004, 0, 1, 1, "R4 load dropped");
    // R5 fetch side
    step(0, 0, '0, 0, '0, 1, 2'b00, 32'hBBBB_0000, 1, 0, 1, "R5 fetch masked");
    step(0, 0, '0, 0, '0, 1, 2'b00, 32'hBBBB_0010, 1, 1, 0, "R5 fetch trap R7");
    // R6 data side
    step(0, 0, '0, 0, '0, 1, 2'b10, 32'hCCCC_0000, 1, 1, 0, "R6 store masked");
    step(0, 0, '0, 0, '0, 1, 2'b10, 32'hCCCC_0020, 1, 0, 1, "R6 store trap R7");
    step(0, 0, '0, 0, '0, 1, 2'b01, 32'hCCCC_0030, 1, 0, 1, "R6 load trap");
    step(0, 0, '0, 0, '0, 1, 2'b11, 32'hCCCC_0040, 1, 0, 1, "R6 kind 11 data side");
    // R8 priority
    step(0, 0, '0, 1, 32'h0000_0400, 1, 2'b01, 32'hDDDD_0000, 1, 1, 1, "R8 stack wins");
    idle("R10 hold");

    // Random mix around a programmed window
    for (int i = 0; i < 4000; i++) begin
      bit we, sel, sv, bv, ee, ie, de;
      logic [AW-1:0] wd, sa, ba;
      logic [1:0] bk;
      string tag;
      we  = ($urandom % 16) == 0;
      sel = $urandom % 2;
      wd  = 32'h1000_0000 + ($urandom % 1024);
      sv  = $urandom % 2;
      sa  = 32'h1000_0000 + ($urandom % 1536) - 32'd256;
      bv  = ($urandom % 3) == 0;
      bk  = 2'($urandom % 4);
      ba  = $urandom;
      ee  = ($urandom % 4) != 0;
      ie  = $urandom % 2;
      de  = $urandom % 2;
      if (win_fault(sv, sa, m_lo, m_hi)) tag = (bv ? "R8 rand" : "R3 rand");
      else if (bv && !ee) tag = "R4 rand";
      else if (bv && bk == 2'b00) tag = "R5 rand";
      else if (bv) tag = "R6 rand";
      else if (we) tag = "R9 rand";
      else tag = "R10 rand";
      step(we, sel, wd, sv, sa, bv, bk, ba, ee, ie, de, tag);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule